// File: doc/BRIEF.md
# Processor Execution Trace Record Packer

This block sits beside a processor core and watches, every clock cycle, the instruction leaving the execute stage, the base and wide register-file ports, the accumulator and flag updates, and the data-memory bus. Everything that happened in one cycle is turned into one trace record: a short run of typed entries that share a cycle stamp. The instruction entry comes first, and the last entry carries an end marker. Entries leave the block one at a time on a valid/ready stream, so a downstream formatter or capture memory can take them at its own rate.

The core is never held back. Records go into a FIFO whole or not at all. When a record does not fit, it is discarded and the next record that is stored is flagged as following a loss. Data-memory writes are classified by their bit mask. An all-ones mask is a full-width store. A mask that covers exactly one 32-bit lane is a word store, and its byte address is rebuilt from the lane position. Any other mask produces an error entry that carries both the mask and the data.

Top module: `trc_packer`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is low. The cycle stamp counts clock edges since reset was released, starting at 0.
- R2: Each cycle with any traced activity adds exactly one record, and an idle cycle adds none. Every entry of a record carries the same `out_cycle`, equal to the stamp of the cycle in which it was captured.
- R3: When `insn_done` is high the record opens with an execute entry (tag 0). Otherwise, when `insn_stall` is high, it opens with a stall entry (tag 1). Execute wins when both are high. `out_key` holds the PC and `out_val` holds the instruction word, zero-extended.
- R4: After the instruction entry the entries come in fixed order: base reads in port order, base write, wide reads in port order, wide write, accumulator write, flag write, memory read, memory write. Only the first entry of a record may have tag 0 or 1.
- R5: Register reads use tag 2 and register writes use tag 3. `out_key[7:6]` gives the register class (0 base, 1 wide, 2 accumulator, 3 flag group) and `out_key[4:0]` gives the index or the flag group; all other key bits are zero. `out_val` is the value, zero-extended. For flags, bits 3..0 hold carry, MSB, LSB and zero.
- R6: A memory read gives tag 4, with the address rounded down to a WLEN/8-byte boundary and the full read data.
- R7: A memory write with an all-ones mask gives tag 5, with the aligned address, the full data and a zero `out_mask`.
- R8: A memory write whose mask covers 32-bit lane i (bits 32i+31..32i) fully and nothing else gives tag 6. The key is the aligned address plus 4·i, and the value is that lane's data, zero-extended.
- R9: Any other write mask, including all-zero, gives tag 7 with the aligned address, the full data, and the mask on `out_mask`. `out_mask` is zero for every other tag.
- R10: `out_last` is high on the final entry of each record and on no other entry.
- R11: An entry offered with `out_valid` high stays unchanged until `out_ready` is seen high. Entries come out in capture order.
- R12: A record is stored only if all of its entries fit in the DEPTH-entry FIFO; otherwise it is dropped whole and the inputs are never stalled. The next stored record has `out_ovf` high on all of its entries, and the records after it have `out_ovf` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Instruction completes this cycle |
| insn_stall | input | 1 | Instruction is held this cycle |
| insn_pc | input | 32 | Program counter of the instruction |
| insn_word | input | 32 | Raw instruction word |
| gpr_rd_en | input | NBR | Base register read strobes, one per port |
| gpr_rd_idx | input | NBR*5 | Base register read indices |
| gpr_rd_val | input | NBR*32 | Base register read values |
| gpr_wr_en | input | 1 | Base register write strobe |
| gpr_wr_idx | input | 5 | Base register write index |
| gpr_wr_val | input | 32 | Base register write value |
| wdr_rd_en | input | NWRD | Wide register read strobes |
| wdr_rd_idx | input | NWRD*5 | Wide register read indices |
| wdr_rd_val | input | NWRD*WLEN | Wide register read values |
| wdr_wr_en | input | 1 | Wide register write strobe |
| wdr_wr_idx | input | 5 | Wide register write index |
| wdr_wr_val | input | WLEN | Wide register write value |
| acc_wr_en | input | 1 | Accumulator write strobe |
| acc_wr_val | input | WLEN | Accumulator write value |
| flg_wr_en | input | 1 | Flag group write strobe |
| flg_wr_grp | input | 1 | Flag group number |
| flg_wr_val | input | 4 | Flags {carry, MSB, LSB, zero} |
| dmem_rd_en | input | 1 | Data memory read strobe |
| dmem_rd_addr | input | 32 | Data memory read byte address |
| dmem_rd_data | input | WLEN | Data memory read data |
| dmem_wr_en | input | 1 | Data memory write strobe |
| dmem_wr_addr | input | 32 | Data memory write byte address |
| dmem_wr_mask | input | WLEN | Data memory write bit mask |
| dmem_wr_data | input | WLEN | Data memory write data |
| out_valid | output | 1 | Entry offered |
| out_ready | input | 1 | Consumer takes the entry |
| out_tag | output | 3 | Entry type |
| out_last | output | 1 | Final entry of its record |
| out_ovf | output | 1 | Record follows a dropped record |
| out_cycle | output | 32 | Cycle stamp of the record |
| out_key | output | 32 | PC, register key or byte address |
| out_val | output | WLEN | Instruction word, value or data |
| out_mask | output | WLEN | Write mask of an error entry, else zero |

## Verification
The directed cycles feed single-source records, one for each write-mask class. A stall followed by an execute of the same PC, and a cycle where done and stall are both high, show whether the tag selection and its priority are right. Partial-lane, two-lane and zero masks are what separate the error class from the word class, and the lane position shows in the rebuilt address. Long random runs with many sources active at once and a random ready pattern check entry ordering, record boundaries and stability under back-pressure. A phase with ready held low pushes full records into a full FIFO, which shows whether a record is dropped whole and whether the loss flag lands on the next stored record only.

// File: rtl/trc_pkg.sv
package trc_pkg;

  // Entry type tags carried on out_tag
  typedef enum logic [2:0] {
    TG_EXEC  = 3'd0,
    TG_STALL = 3'd1,
    TG_RRD   = 3'd2,
    TG_RWR   = 3'd3,
    TG_MRD   = 3'd4,
    TG_MWIDE = 3'd5,
    TG_MWORD = 3'd6,
    TG_MERR  = 3'd7
  } trc_tag_e;

  // Register classes in key bits [7:6]
  localparam logic [1:0] RCL_BASE = 2'd0;
  localparam logic [1:0] RCL_WIDE = 2'd1;
  localparam logic [1:0] RCL_ACC  = 2'd2;
  localparam logic [1:0] RCL_FLAG = 2'd3;

  typedef struct packed {
    trc_tag_e    tag;
    logic        ovf;
    logic        last;
    logic [31:0] cycle;
    logic [31:0] key;
  } trc_hdr_t;

  function automatic logic [31:0] trc_reg_key(input logic [1:0] cls, input logic [4:0] idx);
    return {24'd0, cls, 1'b0, idx};
  endfunction

endpackage

// File: rtl/trc_wmask.sv
// Classifies one data-memory write by its bit mask into wide, word or error.
module trc_wmask #(
  parameter int WLEN = 256
) (
  input  logic [31:0]     addr,
  input  logic [WLEN-1:0] mask,
  input  logic [WLEN-1:0] data,
  output logic [2:0]      tag,
  output logic [31:0]     key,
  output logic [WLEN-1:0] val,
  output logic [WLEN-1:0] msk
);
  import trc_pkg::*;

  localparam int NL = WLEN / 32;
  localparam logic [31:0] ALIGN_M = 32'(WLEN / 8 - 1);

  logic [NL-1:0] lane_full;
  logic [NL-1:0] lane_clear;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign lane_full[l]  = &mask[32*l +: 32];
    assign lane_clear[l] = ~|mask[32*l +: 32];
  end

  logic [31:0] base;
  logic        one_lane;
  logic [31:0] lane_idx;
  logic [31:0] lane_dat;

  always_comb begin
    base     = addr & ~ALIGN_M;
    one_lane = ($countones(lane_full) == 1) && (&(lane_full | lane_clear));
    lane_idx = '0;
    lane_dat = '0;
    for (int l = 0; l < NL; l++) begin
      if (lane_full[l]) begin
        lane_idx = 32'(l);
        lane_dat = data[32*l +: 32];
      end
    end
    if (&lane_full) begin
      tag = 3'(TG_MWIDE);
      key = base;
      val = data;
      msk = '0;
    end else if (one_lane) begin
      tag = 3'(TG_MWORD);
      key = base + (lane_idx << 2);
      val = WLEN'(lane_dat);
      msk = '0;
    end else begin
      tag = 3'(TG_MERR);
      key = base;
      val = data;
      msk = mask;
    end
  end

endmodule

// File: rtl/trc_capture.sv
// Turns one cycle of core activity into an ordered set of candidate entries.
module trc_capture #(
  parameter int WLEN = 256,
  parameter int NBR  = 2,
  parameter int NWRD = 2,
  localparam int NSRC = NBR + NWRD + 7
) (
  input  logic                  insn_done,
  input  logic                  insn_stall,
  input  logic [31:0]           insn_pc,
  input  logic [31:0]           insn_word,
  input  logic [NBR-1:0]        gpr_rd_en,
  input  logic [NBR*5-1:0]      gpr_rd_idx,
  input  logic [NBR*32-1:0]     gpr_rd_val,
  input  logic                  gpr_wr_en,
  input  logic [4:0]            gpr_wr_idx,
  input  logic [31:0]           gpr_wr_val,
  input  logic [NWRD-1:0]       wdr_rd_en,
  input  logic [NWRD*5-1:0]     wdr_rd_idx,
  input  logic [NWRD*WLEN-1:0]  wdr_rd_val,
  input  logic                  wdr_wr_en,
  input  logic [4:0]            wdr_wr_idx,
  input  logic [WLEN-1:0]       wdr_wr_val,
  input  logic                  acc_wr_en,
  input  logic [WLEN-1:0]       acc_wr_val,
  input  logic                  flg_wr_en,
  input  logic                  flg_wr_grp,
  input  logic [3:0]            flg_wr_val,
  input  logic                  dmem_rd_en,
  input  logic [31:0]           dmem_rd_addr,
  input  logic [WLEN-1:0]       dmem_rd_data,
  input  logic                  dmem_wr_en,
  input  logic [31:0]           dmem_wr_addr,
  input  logic [WLEN-1:0]       dmem_wr_mask,
  input  logic [WLEN-1:0]       dmem_wr_data,
  output logic [NSRC-1:0]             src_vld,
  output logic [NSRC-1:0][2:0]        src_tag,
  output logic [NSRC-1:0][31:0]       src_key,
  output logic [NSRC-1:0][WLEN-1:0]   src_val,
  output logic [NSRC-1:0][WLEN-1:0]   src_msk
);
  import trc_pkg::*;

  // Slot positions, fixed so that entries leave in a stable order
  localparam int S_BRD = 1;
  localparam int S_BWR = S_BRD + NBR;
  localparam int S_WRD = S_BWR + 1;
  localparam int S_WWR = S_WRD + NWRD;
  localparam int S_ACC = S_WWR + 1;
  localparam int S_FLG = S_ACC + 1;
  localparam int S_MRD = S_FLG + 1;
  localparam int S_MWR = S_MRD + 1;
  localparam logic [31:0] ALIGN_M = 32'(WLEN / 8 - 1);

  logic [2:0]      mw_tag;
  logic [31:0]     mw_key;
  logic [WLEN-1:0] mw_val;
  logic [WLEN-1:0] mw_msk;

  trc_wmask #(.WLEN(WLEN)) u_wmask (
    .addr (dmem_wr_addr),
    .mask (dmem_wr_mask),
    .data (dmem_wr_data),
    .tag  (mw_tag),
    .key  (mw_key),
    .val  (mw_val),
    .msk  (mw_msk)
  );

  always_comb begin
    src_vld = '0;
    src_tag = '0;
    src_key = '0;
    src_val = '0;
    src_msk = '0;

    src_vld[0] = insn_done | insn_stall;
    src_tag[0] = insn_done ? 3'(TG_EXEC) : 3'(TG_STALL);
    src_key[0] = insn_pc;
    src_val[0] = WLEN'(insn_word);

    for (int i = 0; i < NBR; i++) begin
      src_vld[S_BRD+i] = gpr_rd_en[i];
      src_tag[S_BRD+i] = 3'(TG_RRD);
      src_key[S_BRD+i] = trc_reg_key(RCL_BASE, gpr_rd_idx[5*i +: 5]);
      src_val[S_BRD+i] = WLEN'(gpr_rd_val[32*i +: 32]);
    end

    src_vld[S_BWR] = gpr_wr_en;
    src_tag[S_BWR] = 3'(TG_RWR);
    src_key[S_BWR] = trc_reg_key(RCL_BASE, gpr_wr_idx);
    src_val[S_BWR] = WLEN'(gpr_wr_val);

    for (int i = 0; i < NWRD; i++) begin
      src_vld[S_WRD+i] = wdr_rd_en[i];
      src_tag[S_WRD+i] = 3'(TG_RRD);
      src_key[S_WRD+i] = trc_reg_key(RCL_WIDE, wdr_rd_idx[5*i +: 5]);
      src_val[S_WRD+i] = wdr_rd_val[WLEN*i +: WLEN];
    end

    src_vld[S_WWR] = wdr_wr_en;
    src_tag[S_WWR] = 3'(TG_RWR);
    src_key[S_WWR] = trc_reg_key(RCL_WIDE, wdr_wr_idx);
    src_val[S_WWR] = wdr_wr_val;

    src_vld[S_ACC] = acc_wr_en;
    src_tag[S_ACC] = 3'(TG_RWR);
    src_key[S_ACC] = trc_reg_key(RCL_ACC, 5'd0);
    src_val[S_ACC] = acc_wr_val;

    src_vld[S_FLG] = flg_wr_en;
    src_tag[S_FLG] = 3'(TG_RWR);
    src_key[S_FLG] = trc_reg_key(RCL_FLAG, {4'd0, flg_wr_grp});
    src_val[S_FLG] = WLEN'(flg_wr_val);

    src_vld[S_MRD] = dmem_rd_en;
    src_tag[S_MRD] = 3'(TG_MRD);
    src_key[S_MRD] = dmem_rd_addr & ~ALIGN_M;
    src_val[S_MRD] = dmem_rd_data;

    src_vld[S_MWR] = dmem_wr_en;
    src_tag[S_MWR] = mw_tag;
    src_key[S_MWR] = mw_key;
    src_val[S_MWR] = mw_val;
    src_msk[S_MWR] = mw_msk;
  end

endmodule

// File: rtl/trc_mfifo.sv
// FIFO that stores a compacted group of up to NW entries in one cycle.
module trc_mfifo #(
  parameter int EW    = 64,
  parameter int DEPTH = 16,
  parameter int NW    = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push_en,
  input  logic [NW-1:0]          in_vld,
  input  logic [NW-1:0][EW-1:0]  in_dat,
  input  logic                   pop,
  output logic [EW-1:0]          head,
  output logic [CW-1:0]          used
);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] pos [NW];
  logic [CW-1:0] nadd;

  always_comb begin
    int run;
    run = 0;
    for (int k = 0; k < NW; k++) begin
      pos[k] = CW'(run);
      run    = run + int'(in_vld[k]);
    end
    nadd = CW'(run);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NW; k++) begin
      if (push_en && in_vld[k]) mem[wptr + pos[k][AW-1:0]] <= in_dat[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      used <= '0;
    end else begin
      if (push_en) wptr <= wptr + nadd[AW-1:0];
      if (pop)     rptr <= rptr + AW'(1);
      used <= used + (push_en ? nadd : '0) - CW'(pop);
    end
  end

  assign head = mem[rptr];

endmodule

// File: rtl/trc_packer.sv
// Packs each cycle's core activity into one record and streams its entries.
module trc_packer #(
  parameter int WLEN  = 256,
  parameter int NBR   = 2,
  parameter int NWRD  = 2,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  insn_done,
  input  logic                  insn_stall,
  input  logic [31:0]           insn_pc,
  input  logic [31:0]           insn_word,
  input  logic [NBR-1:0]        gpr_rd_en,
  input  logic [NBR*5-1:0]      gpr_rd_idx,
  input  logic [NBR*32-1:0]     gpr_rd_val,
  input  logic                  gpr_wr_en,
  input  logic [4:0]            gpr_wr_idx,
  input  logic [31:0]           gpr_wr_val,
  input  logic [NWRD-1:0]       wdr_rd_en,
  input  logic [NWRD*5-1:0]     wdr_rd_idx,
  input  logic [NWRD*WLEN-1:0]  wdr_rd_val,
  input  logic                  wdr_wr_en,
  input  logic [4:0]            wdr_wr_idx,
  input  logic [WLEN-1:0]       wdr_wr_val,
  input  logic                  acc_wr_en,
  input  logic [WLEN-1:0]       acc_wr_val,
  input  logic                  flg_wr_en,
  input  logic                  flg_wr_grp,
  input  logic [3:0]            flg_wr_val,
  input  logic                  dmem_rd_en,
  input  logic [31:0]           dmem_rd_addr,
  input  logic [WLEN-1:0]       dmem_rd_data,
  input  logic                  dmem_wr_en,
  input  logic [31:0]           dmem_wr_addr,
  input  logic [WLEN-1:0]       dmem_wr_mask,
  input  logic [WLEN-1:0]       dmem_wr_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2:0]            out_tag,
  output logic                  out_last,
  output logic                  out_ovf,
  output logic [31:0]           out_cycle,
  output logic [31:0]           out_key,
  output logic [WLEN-1:0]       out_val,
  output logic [WLEN-1:0]       out_mask
);
  import trc_pkg::*;

  localparam int NSRC = NBR + NWRD + 7;
  localparam int HW   = $bits(trc_hdr_t);
  localparam int EW   = HW + 2 * WLEN;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [NSRC-1:0]           src_vld;
  logic [NSRC-1:0][2:0]      src_tag;
  logic [NSRC-1:0][31:0]     src_key;
  logic [NSRC-1:0][WLEN-1:0] src_val;
  logic [NSRC-1:0][WLEN-1:0] src_msk;

  trc_capture #(.WLEN(WLEN), .NBR(NBR), .NWRD(NWRD)) u_cap (
    .insn_done, .insn_stall, .insn_pc, .insn_word,
    .gpr_rd_en, .gpr_rd_idx, .gpr_rd_val,
    .gpr_wr_en, .gpr_wr_idx, .gpr_wr_val,
    .wdr_rd_en, .wdr_rd_idx, .wdr_rd_val,
    .wdr_wr_en, .wdr_wr_idx, .wdr_wr_val,
    .acc_wr_en, .acc_wr_val,
    .flg_wr_en, .flg_wr_grp, .flg_wr_val,
    .dmem_rd_en, .dmem_rd_addr, .dmem_rd_data,
    .dmem_wr_en, .dmem_wr_addr, .dmem_wr_mask, .dmem_wr_data,
    .src_vld, .src_tag, .src_key, .src_val, .src_msk
  );

  logic [31:0] cyc_q;
  logic        loss_q;
  logic [CW-1:0] used;
  logic [EW-1:0] head;
  logic          accept, pop, load;
  logic [NSRC-1:0][EW-1:0] ent;

  // Build entries, mark the final one, decide admission of the whole record
  always_comb begin
    logic     seen;
    int       n;
    trc_hdr_t h;
    seen = 1'b0;
    n    = 0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      h.tag   = trc_tag_e'(src_tag[k]);
      h.ovf   = loss_q;
      h.last  = src_vld[k] & ~seen;
      h.cycle = cyc_q;
      h.key   = src_key[k];
      ent[k]  = {h, src_val[k], src_msk[k]};
      seen    = seen | src_vld[k];
      n       = n + int'(src_vld[k]);
    end
    accept = (n != 0) && (n <= DEPTH - int'(used));
  end

  trc_mfifo #(.EW(EW), .DEPTH(DEPTH), .NW(NSRC)) u_fifo (
    .clk, .rst,
    .push_en (accept),
    .in_vld  (src_vld),
    .in_dat  (ent),
    .pop,
    .head,
    .used
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      loss_q <= 1'b0;
    end else begin
      cyc_q <= cyc_q + 32'd1;
      if (accept)          loss_q <= 1'b0;
      else if (|src_vld)   loss_q <= 1'b1;
    end
  end

  // Registered output stage
  logic          ov_q;
  logic [EW-1:0] out_q;

  assign load = ~ov_q | out_ready;
  assign pop  = load & (used != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q  <= 1'b0;
      out_q <= '0;
    end else if (load) begin
      ov_q <= pop;
      if (pop) out_q <= head;
    end
  end

  trc_hdr_t oh;
  assign oh        = out_q[EW-1 -: HW];
  assign out_valid = ov_q;
  assign out_tag   = oh.tag;
  assign out_ovf   = oh.ovf;
  assign out_last  = oh.last;
  assign out_cycle = oh.cycle;
  assign out_key   = oh.key;
  assign out_val   = out_q[2*WLEN-1 -: WLEN];
  assign out_mask  = out_q[WLEN-1:0];

endmodule

// File: rtl/trc_packer_chk.sv
module trc_packer_chk #(
  parameter int WLEN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic            out_ready,
  input logic [2:0]      out_tag,
  input logic            out_last,
  input logic [31:0]     out_cycle,
  input logic [31:0]     out_key,
  input logic [WLEN-1:0] out_val,
  input logic [WLEN-1:0] out_mask
);
  localparam int AB = $clog2(WLEN / 8);

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  assert_same_record_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_cycle == $past(out_cycle)));

  assert_lead_first_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> (out_tag != 3'd0 && out_tag != 3'd1));

  assert_read_align_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_tag == 3'd4 || out_tag == 3'd5)) |-> (out_key[AB-1:0] == '0));

  assert_word_shape_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag == 3'd6) |-> (out_val[WLEN-1:32] == '0 && out_key[1:0] == 2'd0));

  assert_mask_err_only_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tag != 3'd7) |-> (out_mask == '0));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_key) &&
                                   $stable(out_val) && $stable(out_last) && $stable(out_cycle)));

endmodule

bind trc_packer trc_packer_chk #(.WLEN(WLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_tag   (out_tag),
  .out_last  (out_last),
  .out_cycle (out_cycle),
  .out_key   (out_key),
  .out_val   (out_val),
  .out_mask  (out_mask)
);

// File: tb/trc_packer_tb.sv
`timescale 1ns/1ps
module trc_packer_tb;
  localparam int WLEN = 256, NBR = 2, NWRD = 2, DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic insn_done, insn_stall;
  logic [31:0] insn_pc, insn_word;
  logic [NBR-1:0] gpr_rd_en;
  logic [NBR*5-1:0] gpr_rd_idx;
  logic [NBR*32-1:0] gpr_rd_val;
  logic gpr_wr_en; logic [4:0] gpr_wr_idx; logic [31:0] gpr_wr_val;
  logic [NWRD-1:0] wdr_rd_en;
  logic [NWRD*5-1:0] wdr_rd_idx;
  logic [NWRD*WLEN-1:0] wdr_rd_val;
  logic wdr_wr_en; logic [4:0] wdr_wr_idx; logic [WLEN-1:0] wdr_wr_val;
  logic acc_wr_en; logic [WLEN-1:0] acc_wr_val;
  logic flg_wr_en, flg_wr_grp; logic [3:0] flg_wr_val;
  logic dmem_rd_en; logic [31:0] dmem_rd_addr; logic [WLEN-1:0] dmem_rd_data;
  logic dmem_wr_en; logic [31:0] dmem_wr_addr; logic [WLEN-1:0] dmem_wr_mask, dmem_wr_data;
  logic out_valid, out_ready, out_last, out_ovf;
  logic [2:0] out_tag;
  logic [31:0] out_cycle, out_key;
  logic [WLEN-1:0] out_val, out_mask;

  trc_packer #(.WLEN(WLEN), .NBR(NBR), .NWRD(NWRD), .DEPTH(DEPTH)) u_dut (.*);

  int nchk = 0, nerr = 0;
  bit done = 0, saw_ovf = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [WLEN-1:0] act, input logic [WLEN-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    bit [2:0] tag; bit ovf; bit last; bit [31:0] cyc;
    bit [31:0] key; bit [WLEN-1:0] val; bit [WLEN-1:0] msk;
  } exp_t;

  exp_t q[$];
  exp_t rec[$];
  exp_t m_out;
  bit   m_ov = 0, pend = 0;
  bit [31:0] m_cyc = 0;

  task automatic add(input bit [2:0] t, input bit [31:0] k, input bit [WLEN-1:0] v,
                     input bit [WLEN-1:0] m);
    exp_t e;
    e.tag = t; e.key = k; e.val = v; e.msk = m; e.ovf = 0; e.last = 0; e.cyc = m_cyc;
    rec.push_back(e);
  endtask

  function automatic bit [31:0] rkey(input bit [1:0] c, input bit [4:0] i);
    return {24'd0, c, 1'b0, i};
  endfunction

  task automatic build();
    rec.delete();
    if (insn_done) add(3'd0, insn_pc, WLEN'(insn_word), '0);
    else if (insn_stall) add(3'd1, insn_pc, WLEN'(insn_word), '0);
    for (int i = 0; i < NBR; i++)
      if (gpr_rd_en[i]) add(3'd2, rkey(2'd0, gpr_rd_idx[5*i +: 5]), WLEN'(gpr_rd_val[32*i +: 32]), '0);
    if (gpr_wr_en) add(3'd3, rkey(2'd0, gpr_wr_idx), WLEN'(gpr_wr_val), '0);
    for (int i = 0; i < NWRD; i++)
      if (wdr_rd_en[i]) add(3'd2, rkey(2'd1, wdr_rd_idx[5*i +: 5]), wdr_rd_val[WLEN*i +: WLEN], '0);
    if (wdr_wr_en) add(3'd3, rkey(2'd1, wdr_wr_idx), wdr_wr_val, '0);
    if (acc_wr_en) add(3'd3, rkey(2'd2, 5'd0), acc_wr_val, '0);
    if (flg_wr_en) add(3'd3, rkey(2'd3, {4'd0, flg_wr_grp}), WLEN'(flg_wr_val), '0);
    if (dmem_rd_en) add(3'd4, dmem_rd_addr & ~32'h1f, dmem_rd_data, '0);
    if (dmem_wr_en) begin
      int nfull = 0, lane = 0; bit clean = 1;
      for (int l = 0; l < WLEN/32; l++) begin
        if (dmem_wr_mask[32*l +: 32] == 32'hffffffff) begin nfull++; lane = l; end
        else if (dmem_wr_mask[32*l +: 32] != 32'd0) clean = 0;
      end
      if (nfull == WLEN/32) add(3'd5, dmem_wr_addr & ~32'h1f, dmem_wr_data, '0);
      else if (nfull == 1 && clean)
        add(3'd6, (dmem_wr_addr & ~32'h1f) + 32'(4*lane), WLEN'(dmem_wr_data[32*lane +: 32]), '0);
      else add(3'd7, dmem_wr_addr & ~32'h1f, dmem_wr_data, dmem_wr_mask);
    end
    if (rec.size() > 0) rec[rec.size()-1].last = 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_ov = 0; pend = 0; m_cyc = 0;
    end else begin
      int  free; bit acc;
      build();
      free = DEPTH - q.size();
      acc  = rec.size() > 0 && rec.size() <= free;
      if (!m_ov || out_ready) begin
        if (q.size() > 0) begin m_out = q.pop_front(); m_ov = 1; end
        else m_ov = 0;
      end
      if (rec.size() > 0) begin
        if (acc) begin
          foreach (rec[i]) begin rec[i].ovf = pend; q.push_back(rec[i]); end
          pend = 0;
        end else pend = 1;
      end
      m_cyc++;
    end
  end

  function automatic string rq_of(input bit [2:0] t);
    case (t)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == m_ov, "R11", "valid", WLEN'(out_valid), WLEN'(m_ov));
      if (m_ov && out_valid) begin
        chk(out_tag == m_out.tag, (m_out.tag > 3'd1) ? "R4" : "R3", "tag", WLEN'(out_tag), WLEN'(m_out.tag));
        chk(out_key == m_out.key, rq_of(m_out.tag), "key", WLEN'(out_key), WLEN'(m_out.key));
        chk(out_val == m_out.val, rq_of(m_out.tag), "val", out_val, m_out.val);
        chk(out_mask == m_out.msk, "R9", "mask", out_mask, m_out.msk);
        chk(out_cycle == m_out.cyc, "R2", "cycle", WLEN'(out_cycle), WLEN'(m_out.cyc));
        chk(out_last == m_out.last, "R10", "last", WLEN'(out_last), WLEN'(m_out.last));
        chk(out_ovf == m_out.ovf, "R12", "ovf", WLEN'(out_ovf), WLEN'(m_out.ovf));
        if (out_ovf && m_out.ovf) saw_ovf = 1;
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic bit [WLEN-1:0] rw();
    bit [WLEN-1:0] v;
    for (int i = 0; i < WLEN/32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic bit [WLEN-1:0] lane_mask(input int l);
    bit [WLEN-1:0] m = '0;
    m[32*l +: 32] = 32'hffffffff;
    return m;
  endfunction

  task automatic idle();
    insn_done = 0; insn_stall = 0; gpr_rd_en = '0; gpr_wr_en = 0; wdr_rd_en = '0;
    wdr_wr_en = 0; acc_wr_en = 0; flg_wr_en = 0; dmem_rd_en = 0; dmem_wr_en = 0;
  endtask

  task automatic rand_vals();
    insn_pc = $urandom; insn_word = $urandom;
    gpr_rd_idx = NBR*5'($urandom); gpr_rd_val = {$urandom, $urandom};
    gpr_wr_idx = 5'($urandom); gpr_wr_val = $urandom;
    wdr_rd_idx = NWRD*5'($urandom); wdr_rd_val = {rw(), rw()};
    wdr_wr_idx = 5'($urandom); wdr_wr_val = rw(); acc_wr_val = rw();
    flg_wr_grp = 1'($urandom); flg_wr_val = 4'($urandom);
    dmem_rd_addr = $urandom; dmem_rd_data = rw();
    dmem_wr_addr = $urandom; dmem_wr_data = rw();
    case ($urandom % 5)
      0: dmem_wr_mask = '1;
      1: dmem_wr_mask = lane_mask($urandom % 8);
      2: dmem_wr_mask = lane_mask($urandom % 8) ^ WLEN'(1);
      3: dmem_wr_mask = lane_mask($urandom % 8) | lane_mask($urandom % 8);
      default: dmem_wr_mask = rw();
    endcase
  endtask

  task automatic rand_rec(input int p);
    rand_vals();
    insn_done = ($urandom % 100) < p; insn_stall = ($urandom % 100) < p;
    for (int i = 0; i < NBR; i++) gpr_rd_en[i] = ($urandom % 100) < p;
    for (int i = 0; i < NWRD; i++) wdr_rd_en[i] = ($urandom % 100) < p;
    gpr_wr_en = ($urandom % 100) < p; wdr_wr_en = ($urandom % 100) < p;
    acc_wr_en = ($urandom % 100) < p; flg_wr_en = ($urandom % 100) < p;
    dmem_rd_en = ($urandom % 100) < p; dmem_wr_en = ($urandom % 100) < p;
  endtask

  task automatic mwrite(input bit [WLEN-1:0] m);
    @(negedge clk); idle(); rand_vals();
    insn_done = 1; dmem_wr_en = 1; dmem_wr_mask = m;
  endtask

  initial begin
    idle(); rand_vals(); out_ready = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R1", "valid in reset", WLEN'(out_valid), '0);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1", "valid after reset", WLEN'(out_valid), '0);

    // Directed: stall then matching execute; done and stall together
    idle(); rand_vals(); insn_stall = 1; insn_pc = 32'h0000_0150;
    @(negedge clk); insn_stall = 0; insn_done = 1; gpr_rd_en = 2'b11; gpr_wr_en = 1;
    @(negedge clk); idle(); insn_done = 1; insn_stall = 1; flg_wr_en = 1; acc_wr_en = 1;
    @(negedge clk); idle();
    @(negedge clk); idle(); rand_vals(); dmem_rd_en = 1;       // record with no instruction entry
    mwrite('1);                                               // wide
    mwrite(lane_mask(0));                                     // word, lane 0
    mwrite(lane_mask(7));                                     // word, top lane
    mwrite(lane_mask(3) ^ (WLEN'(1) << 100));                 // partial lane
    mwrite(lane_mask(2) | lane_mask(5));                      // two lanes
    mwrite('0);                                               // empty mask
    @(negedge clk); idle();
    repeat (5) @(negedge clk);

    // Random traffic with back-pressure
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      idle();
      out_ready = ($urandom % 100) < 70;
      if (($urandom % 100) < 30) rand_rec(25 + int'($urandom % 50));
    end
    @(negedge clk); idle(); out_ready = 1;
    repeat (80) @(negedge clk);

    // Overflow: full records into a stalled stream
    out_ready = 0;
    for (int r = 0; r < 3; r++) begin @(negedge clk); rand_rec(100); end
    @(negedge clk); idle(); rand_vals(); insn_done = 1; gpr_wr_en = 1;
    @(negedge clk); idle(); rand_vals(); insn_done = 1;
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    out_ready = 1;
    repeat (60) @(negedge clk);
    chk(saw_ovf, "R12", "loss flag seen", WLEN'(saw_ovf), WLEN'(1));

    // Heavy random traffic with rare ready to provoke repeated drops
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      idle();
      out_ready = ($urandom % 100) < 40;
      if (($urandom % 100) < 60) rand_rec(60);
    end
    @(negedge clk); idle(); out_ready = 1;
    repeat (80) @(negedge clk);
    chk(out_valid == 0 && q.size() == 0, "R11", "drained", WLEN'(out_valid), '0);
    done = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      report();
    end
  end

endmodule